// File: doc/BRIEF.md
# Streaming Packet Payload and Sequence Checker

This block sits passively on a streaming receive interface made of a valid qualifier, start and end markers and a 32-bit data word. It never drives the stream. The block regenerates a 32-bit pseudo-random reference sequence on its own and compares every payload word against it. It treats the low byte of the first word of each packet as a packet identifier, and that identifier must rise by one from packet to packet. It also counts the packets it sees, so that a test can compare the total with an expected figure at the end of the run.

Each kind of error has its own flag, which stays set once raised, and its own error counter. A single configuration bit says whether the monitored port carries regular traffic or high-priority traffic. Packets are counted into the matching one of two counters. A one-cycle strobe compares the counter for the selected traffic class with the expected count presented on a configuration input.

Top module: `pkt_stream_checker`

## Requirements
- R1: While reset is applied and until the first stream beat, all four error flags, all four error counters and both packet counters read zero.
- R2: A payload beat is a beat with `rx_valid`=1 and `rx_sop`=0. It is compared with a reference word. The reference starts at SEED (default 32'h1ACEB00C) and moves to {s[30:0], s[31]^s[21]^s[1]^s[0]} after each payload beat. A mismatch sets `err_flags[0]` and increments `data_err_cnt`.
- R3: On a beat with `rx_valid`=1 and `rx_sop`=1, bits [7:0] are the identifier and bits [31:8] are ignored. That beat is not a payload beat. The first identifier after reset is accepted as is. Each later identifier must equal the previous one plus one, modulo 256. A violation sets `err_flags[1]` and increments `id_err_cnt`. The received identifier always becomes the new previous value.
- R4: A start beat that arrives while a packet is open, or an end beat without a start while no packet is open, sets `err_flags[2]` and increments `frame_err_cnt`. A packet opens on a start beat that has `rx_eop`=0 and closes on any beat that has `rx_eop`=1.
- R5: Every start beat increments `pkt_cnt_prio` when `cfg_high_prio`=1 and `pkt_cnt_normal` otherwise.
- R6: When `cnt_check`=1, the packet counter selected by `cfg_high_prio` is compared with `cfg_expect_cnt`, using its value from before that cycle's beat. If they differ, `err_flags[3]` is set and `count_err_cnt` increments.
- R7: Error flags stay set until reset. All counters saturate at 65535.
- R8: A cycle with `rx_valid`=0 changes nothing, whatever `rx_sop`, `rx_eop` and `rx_data` carry. In particular it does not advance the reference sequence.
- R9: All results appear on the outputs one clock after the beat or strobe that causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_high_prio | input | 1 | 1: monitored port carries high-priority packets |
| cfg_expect_cnt | input | 16 | Expected packet count for the count comparison |
| cnt_check | input | 1 | One-cycle strobe that starts the count comparison |
| rx_valid | input | 1 | Beat qualifier |
| rx_sop | input | 1 | First beat of a packet |
| rx_eop | input | 1 | Last beat of a packet |
| rx_data | input | 32 | Stream data word |
| err_flags | output | 4 | Sticky flags: bit0 data, bit1 identifier, bit2 framing, bit3 count |
| data_err_cnt | output | 16 | Payload mismatch count |
| id_err_cnt | output | 16 | Identifier sequence error count |
| frame_err_cnt | output | 16 | Framing error count |
| count_err_cnt | output | 16 | Failed count comparisons |
| pkt_cnt_normal | output | 16 | Regular packets received |
| pkt_cnt_prio | output | 16 | High-priority packets received |

## Verification
The hardest state to reach from the ports is error-counter saturation. Reaching it takes more than sixty-five thousand faulty payload beats. The stimulus gets there with a long, uncompared burst of deliberately corrupted words, and then checks that the counter holds at its ceiling. The identifier wrap from 255 to 0 is reached by starting the directed packets at identifier 252. Random packets with idle gaps, single-bit corruptions, skipped identifiers and count strobes then exercise the interleavings.

// File: rtl/pkc_pkg.sv
package pkc_pkg;
  localparam int unsigned LFSR_W   = 32;
  localparam int unsigned NUM_ERR  = 4;
  localparam int unsigned ERR_DATA = 0;
  localparam int unsigned ERR_ID   = 1;
  localparam int unsigned ERR_FRM  = 2;
  localparam int unsigned ERR_CNT  = 3;

  // maximal-length taps 32,22,2,1, shifting left
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction
endpackage

// File: rtl/pkc_rst_sync.sv
module pkc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pkc_lfsr.sv
module pkc_lfsr import pkc_pkg::*; #(
  parameter logic [LFSR_W-1:0] SEED = 32'h1ACE_B00C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [LFSR_W-1:0] ref_word
);
  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] state_d;

  always_comb begin
    state_d = state_q;
    if (adv) state_d = lfsr_step(state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign ref_word = state_q;
endmodule

// File: rtl/pkc_sat_cnt.sv
module pkc_sat_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CEIL = '1;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc && (cnt_q != CEIL)) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pkc_frame.sv
module pkc_frame #(
  parameter int unsigned ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid,
  input  logic            sop,
  input  logic            eop,
  input  logic [ID_W-1:0] id_in,
  output logic            in_pkt,
  output logic            frame_hit,
  output logic            id_hit,
  output logic            pkt_start
);
  logic            open_q,  open_d;
  logic            seen_q,  seen_d;
  logic [ID_W-1:0] last_q,  last_d;
  logic [ID_W-1:0] id_want;

  assign id_want   = last_q + ID_W'(1);
  assign pkt_start = valid & sop;
  assign frame_hit = valid & ((sop & open_q) | (eop & ~sop & ~open_q));
  assign id_hit    = pkt_start & seen_q & (id_in != id_want);
  assign in_pkt    = open_q;

  always_comb begin
    open_d = open_q;
    seen_d = seen_q;
    last_d = last_q;
    if (valid) begin
      if (sop) begin
        open_d = ~eop;
        seen_d = 1'b1;
        last_d = id_in;
      end else if (eop) begin
        open_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      seen_q <= 1'b0;
      last_q <= '0;
    end else begin
      open_q <= open_d;
      seen_q <= seen_d;
      last_q <= last_d;
    end
  end
endmodule

// File: rtl/pkt_stream_checker.sv
module pkt_stream_checker import pkc_pkg::*; #(
  parameter logic [LFSR_W-1:0] SEED  = 32'h1ACE_B00C,
  parameter int unsigned       CNT_W = 16,
  parameter int unsigned       ID_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_high_prio,
  input  logic [CNT_W-1:0]  cfg_expect_cnt,
  input  logic              cnt_check,
  input  logic              rx_valid,
  input  logic              rx_sop,
  input  logic              rx_eop,
  input  logic [LFSR_W-1:0] rx_data,
  output logic [NUM_ERR-1:0] err_flags,
  output logic [CNT_W-1:0]  data_err_cnt,
  output logic [CNT_W-1:0]  id_err_cnt,
  output logic [CNT_W-1:0]  frame_err_cnt,
  output logic [CNT_W-1:0]  count_err_cnt,
  output logic [CNT_W-1:0]  pkt_cnt_normal,
  output logic [CNT_W-1:0]  pkt_cnt_prio
);
  logic               rst_sync_n;
  logic [LFSR_W-1:0]  lfsr_ref;
  logic               payload_beat;
  logic               in_pkt;
  logic               frame_hit;
  logic               id_hit;
  logic               pkt_start;
  logic [CNT_W-1:0]   sel_cnt;
  logic [NUM_ERR-1:0] err_hit;
  logic [NUM_ERR-1:0] flag_q;
  logic [NUM_ERR-1:0] flag_d;
  logic [CNT_W-1:0]   err_cnt [NUM_ERR];

  pkc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign payload_beat = rx_valid & ~rx_sop;

  pkc_lfsr #(.SEED(SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_sync_n), .adv(payload_beat), .ref_word(lfsr_ref)
  );

  pkc_frame #(.ID_W(ID_W)) u_frame (
    .clk(clk), .rst_n(rst_sync_n), .valid(rx_valid), .sop(rx_sop),
    .eop(rx_eop), .id_in(rx_data[ID_W-1:0]), .in_pkt(in_pkt),
    .frame_hit(frame_hit), .id_hit(id_hit), .pkt_start(pkt_start)
  );

  // packet counters, one per traffic class
  pkc_sat_cnt #(.W(CNT_W)) u_pkt_normal (
    .clk(clk), .rst_n(rst_sync_n), .inc(pkt_start & ~cfg_high_prio),
    .cnt(pkt_cnt_normal)
  );
  pkc_sat_cnt #(.W(CNT_W)) u_pkt_prio (
    .clk(clk), .rst_n(rst_sync_n), .inc(pkt_start & cfg_high_prio),
    .cnt(pkt_cnt_prio)
  );

  assign sel_cnt = cfg_high_prio ? pkt_cnt_prio : pkt_cnt_normal;

  always_comb begin
    err_hit          = '0;
    err_hit[ERR_DATA] = payload_beat & (rx_data != lfsr_ref);
    err_hit[ERR_ID]   = id_hit;
    err_hit[ERR_FRM]  = frame_hit;
    err_hit[ERR_CNT]  = cnt_check & (sel_cnt != cfg_expect_cnt);
  end

  always_comb begin
    flag_d = flag_q | err_hit;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) flag_q <= '0;
    else             flag_q <= flag_d;
  end

  for (genvar g = 0; g < NUM_ERR; g++) begin : g_err
    pkc_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_sync_n), .inc(err_hit[g]), .cnt(err_cnt[g])
    );
  end

  assign err_flags     = flag_q;
  assign data_err_cnt  = err_cnt[ERR_DATA];
  assign id_err_cnt    = err_cnt[ERR_ID];
  assign frame_err_cnt = err_cnt[ERR_FRM];
  assign count_err_cnt = err_cnt[ERR_CNT];
endmodule

// File: rtl/pkc_checker.sv
module pkc_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_sync_n,
  input logic             rx_valid,
  input logic             rx_sop,
  input logic [31:0]      rx_data,
  input logic             cfg_high_prio,
  input logic             in_pkt,
  input logic [31:0]      lfsr_ref,
  input logic [3:0]       err_flags,
  input logic [CNT_W-1:0] data_err_cnt,
  input logic [CNT_W-1:0] id_err_cnt,
  input logic [CNT_W-1:0] frame_err_cnt,
  input logic [CNT_W-1:0] pkt_cnt_normal,
  input logic [CNT_W-1:0] pkt_cnt_prio
);
  localparam logic [CNT_W-1:0] CEIL = '1;

  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (err_flags == '0 && data_err_cnt == '0 &&
                                     pkt_cnt_normal == '0 && pkt_cnt_prio == '0);
    end
  end

  assert_data_flag_R2: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (rx_valid && !rx_sop && rx_data != lfsr_ref) |=> err_flags[0]);

  assert_data_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (!rx_valid || rx_sop) |=> $stable(data_err_cnt));

  assert_frame_sop_R4: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (rx_valid && rx_sop && in_pkt) |=> err_flags[2]);

  assert_pkt_step_R5: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (rx_valid && rx_sop && !cfg_high_prio && pkt_cnt_normal != CEIL)
      |=> pkt_cnt_normal == $past(pkt_cnt_normal) + CNT_W'(1));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (err_flags != '0) |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (data_err_cnt == CEIL) |=> (data_err_cnt == CEIL));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    !rx_valid |=> ($stable(lfsr_ref) && $stable(id_err_cnt) && $stable(frame_err_cnt) &&
                   $stable(pkt_cnt_normal) && $stable(pkt_cnt_prio)));
endmodule

bind pkt_stream_checker pkc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n), .rx_valid(rx_valid),
  .rx_sop(rx_sop), .rx_data(rx_data), .cfg_high_prio(cfg_high_prio),
  .in_pkt(in_pkt), .lfsr_ref(lfsr_ref), .err_flags(err_flags),
  .data_err_cnt(data_err_cnt), .id_err_cnt(id_err_cnt),
  .frame_err_cnt(frame_err_cnt), .pkt_cnt_normal(pkt_cnt_normal),
  .pkt_cnt_prio(pkt_cnt_prio)
);

// File: tb/sim_pkt_stream_checker.sv
`timescale 1ns/1ps
module sim_pkt_stream_checker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_high_prio;
  logic [15:0] cfg_expect_cnt;
  logic        cnt_check;
  logic        rx_valid, rx_sop, rx_eop;
  logic [31:0] rx_data;
  logic [3:0]  err_flags;
  logic [15:0] data_err_cnt, id_err_cnt, frame_err_cnt, count_err_cnt;
  logic [15:0] pkt_cnt_normal, pkt_cnt_prio;

  pkt_stream_checker u0 (
    .clk(clk), .rst_n(rst_n), .cfg_high_prio(cfg_high_prio),
    .cfg_expect_cnt(cfg_expect_cnt), .cnt_check(cnt_check),
    .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_data(rx_data),
    .err_flags(err_flags), .data_err_cnt(data_err_cnt), .id_err_cnt(id_err_cnt),
    .frame_err_cnt(frame_err_cnt), .count_err_cnt(count_err_cnt),
    .pkt_cnt_normal(pkt_cnt_normal), .pkt_cnt_prio(pkt_cnt_prio)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;
  bit do_cmp = 1;

  // reference model state
  logic [31:0] m_lfsr;
  bit          m_open, m_seen;
  logic [7:0]  m_last;
  bit [3:0]    m_flag;
  int          m_cnt [4];
  int          m_pn, m_pp;

  function automatic logic [31:0] ref_next(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void hit(input int k);
    m_flag[k] = 1'b1;
    if (m_cnt[k] < 65535) m_cnt[k]++;
  endfunction

  task automatic compare_all();
    check("R2", "data flag",   32'(err_flags[0]), 32'(m_flag[0]));
    check("R2", "data count",  32'(data_err_cnt), m_cnt[0]);
    check("R3", "id flag",     32'(err_flags[1]), 32'(m_flag[1]));
    check("R3", "id count",    32'(id_err_cnt), m_cnt[1]);
    check("R4", "frame flag",  32'(err_flags[2]), 32'(m_flag[2]));
    check("R4", "frame count", 32'(frame_err_cnt), m_cnt[2]);
    check("R6", "count flag",  32'(err_flags[3]), 32'(m_flag[3]));
    check("R6", "count errs",  32'(count_err_cnt), m_cnt[3]);
    check("R5", "normal pkts", 32'(pkt_cnt_normal), m_pn);
    check("R5", "prio pkts",   32'(pkt_cnt_prio), m_pp);
  endtask

  // one cycle on the stream; results compared one clock later (R9)
  task automatic beat(input bit v, input bit s, input bit e, input logic [31:0] d,
                      input bit chk, input logic [15:0] exp);
    @(negedge clk);
    rx_valid = v; rx_sop = s; rx_eop = e; rx_data = d;
    cnt_check = chk; cfg_expect_cnt = exp;
    if (chk) begin
      if ((cfg_high_prio ? m_pp : m_pn) != int'(exp)) hit(3);
    end
    if (v) begin
      if (s) begin
        if (m_seen && d[7:0] != 8'(m_last + 8'd1)) hit(1);
        m_seen = 1; m_last = d[7:0];
        if (m_open) hit(2);
        m_open = !e;
        if (cfg_high_prio) begin if (m_pp < 65535) m_pp++; end
        else begin if (m_pn < 65535) m_pn++; end
      end else begin
        if (d != m_lfsr) hit(0);
        m_lfsr = ref_next(m_lfsr);
        if (e) begin
          if (!m_open) hit(2);
          m_open = 0;
        end
      end
    end
    @(posedge clk); #1;
    if (do_cmp) compare_all();
  endtask

  task automatic idle();
    beat(0, 0, 0, 32'h0, 0, 16'h0);
  endtask

  // packet of len beats; payload index bad (>=0) gets one bit flipped
  task automatic send_pkt(input logic [7:0] id, input int len, input int bad, input bit gaps);
    beat(1, 1, len == 1, {$urandom() % 32'h0100_0000, 8'h0} | 32'(id), 0, 16'h0);
    for (int i = 1; i < len; i++) begin
      if (gaps && ($urandom() % 4 == 0)) idle();
      beat(1, 0, i == len - 1,
           (i - 1 == bad) ? (m_lfsr ^ (32'h1 << ($urandom() % 32))) : m_lfsr, 0, 16'h0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] nid;
    void'($urandom(32'd77031));
    rst_n = 1'b0;
    cfg_high_prio = 0; cfg_expect_cnt = 0; cnt_check = 0;
    rx_valid = 0; rx_sop = 0; rx_eop = 0; rx_data = 0;
    m_lfsr = 32'h1ACE_B00C; m_open = 0; m_seen = 0; m_last = 0; m_flag = 0;
    foreach (m_cnt[i]) m_cnt[i] = 0;
    m_pn = 0; m_pp = 0;
    repeat (4) @(posedge clk);
    #1;
    check("R1", "flags in reset", 32'(err_flags), 0);
    check("R1", "pkt counts in reset", 32'(pkt_cnt_normal) + 32'(pkt_cnt_prio), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;
    check("R1", "flags after release", 32'(err_flags), 0);
    check("R1", "error counts after release",
          32'(data_err_cnt | id_err_cnt | frame_err_cnt | count_err_cnt), 0);

    // R8: garbage with valid low
    for (int i = 0; i < 12; i++)
      beat(0, 1'($urandom()), 1'($urandom()), $urandom(), 0, 16'h0);
    check("R8", "counts after idle garbage", 32'(pkt_cnt_normal | frame_err_cnt), 0);
    send_pkt(8'hFC, 5, -1, 0);
    check("R8", "seed still first reference", 32'(err_flags[0]), 0);

    // R3 wrap 255 -> 0
    send_pkt(8'hFD, 3, -1, 0);
    send_pkt(8'hFE, 1, -1, 0);
    send_pkt(8'hFF, 4, -1, 0);
    send_pkt(8'h00, 2, -1, 0);
    check("R3", "no id error across wrap", 32'(err_flags[1]), 0);
    send_pkt(8'h03, 2, -1, 0);
    check("R3", "skipped id flagged", 32'(id_err_cnt), 1);
    send_pkt(8'h04, 2, -1, 0);
    check("R3", "resync after skip", 32'(id_err_cnt), 1);

    // R2 corruption
    send_pkt(8'h05, 6, 2, 0);
    check("R2", "single corrupt word", 32'(data_err_cnt), 1);

    // R4 framing
    beat(1, 1, 0, 32'h06, 0, 16'h0);
    beat(1, 0, 0, m_lfsr, 0, 16'h0);
    beat(1, 1, 0, 32'h07, 0, 16'h0);
    check("R4", "start inside packet", 32'(frame_err_cnt), 1);
    beat(1, 0, 1, m_lfsr, 0, 16'h0);
    beat(1, 0, 1, m_lfsr, 0, 16'h0);
    check("R4", "end outside packet", 32'(frame_err_cnt), 2);

    // R5/R6 priority class and count comparison
    idle();
    cfg_high_prio = 1;
    send_pkt(8'h08, 3, -1, 0);
    send_pkt(8'h09, 1, -1, 0);
    check("R5", "prio packets", 32'(pkt_cnt_prio), 2);
    beat(0, 0, 0, 0, 1, 16'd2);
    check("R6", "matching count", 32'(err_flags[3]), 0);
    beat(0, 0, 0, 0, 1, 16'd3);
    check("R6", "mismatching count", 32'(count_err_cnt), 1);
    cfg_high_prio = 0;
    beat(0, 0, 0, 0, 1, 16'(m_pn));
    check("R6", "normal class match", 32'(count_err_cnt), 1);

    // random traffic
    nid = 8'h0A;
    for (int p = 0; p < 400; p++) begin
      int len, bad;
      len = 1 + int'($urandom() % 8);
      bad = ($urandom() % 12 == 0 && len > 1) ? int'($urandom() % (len - 1)) : -1;
      if ($urandom() % 20 == 0) nid = nid + 8'd2;
      send_pkt(nid, len, bad, 1);
      nid = nid + 8'd1;
      if ($urandom() % 10 == 0) begin
        idle();
        cfg_high_prio = 1'($urandom());
      end
      if ($urandom() % 15 == 0)
        beat(0, 0, 0, 0, 1, ($urandom() % 2) ? 16'(cfg_high_prio ? m_pp : m_pn) : 16'($urandom()));
    end

    // R7 saturation of the payload error counter
    do_cmp = 0;
    for (int i = 0; i < 65540; i++) beat(1, 0, 0, ~m_lfsr, 0, 16'h0);
    do_cmp = 1;
    idle();
    check("R7", "data count saturated", 32'(data_err_cnt), 65535);
    check("R7", "flags held", 32'(err_flags & m_flag), 32'(m_flag));
    beat(1, 0, 0, ~m_lfsr, 0, 16'h0);
    check("R7", "no wrap past ceiling", 32'(data_err_cnt), 65535);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule